// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer with three registers on a simple synchronous register bus: a control word, a reload value and the live count. The input clock first passes an 8-bit programmable prescaler and then a fixed power-of-two divider that the control word selects. Each resulting tick lowers a 16-bit down-counter by one. Software proves it is alive by writing the count register from time to time. If it fails to do so, the counter runs out. On expiry the block can latch an interrupt flag, start a system reset-request pulse of fixed length, or do both.

On expiry the counter reloads from the reload register and keeps counting, so a timer with only the interrupt enabled works as a periodic tick source. Changes to the prescaler or divider fields are held back until the current prescaler period has finished. This means a scale change never produces a shortened or partial tick.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control register reads 0xFF1B, both the reload and count registers read 0x8000, and irq_o and rst_req_o are low. In the control register, bit 0 is run enable, bit 1 is reset-on-expiry, bit 2 is interrupt-on-expiry, bits 4:3 are the divider select, bit 5 is the interrupt flag and bits 15:8 are the prescale field. The addresses are control 0, reload 1 and count 2.
- R2: A write to address 2 loads the live counter at that clock edge and takes priority over a tick in the same cycle. Repeated writes made before expiry keep irq_o and rst_req_o low.
- R3: While enabled, the counter drops by one every (P+1)*D input clocks. P is the prescale field, and D is 16, 32, 64 or 128 for divider select 0, 1, 2 or 3. The first decrement falls (P+1)*D edges after the enabling write.
- R4: A tick that finds the count at 1 or 0 is an expiry: the counter reloads from address 1 instead of decrementing. Starting from count = reload = N, expiries therefore repeat every max(N,1)*(P+1)*D clocks.
- R5: When interrupt-on-expiry is set, an expiry sets the interrupt flag and irq_o follows it. The flag stays set until a control write with bit 5 equal to 1 clears it; a control write with bit 5 equal to 0 leaves it set. With interrupt-on-expiry clear, an expiry leaves irq_o low.
- R6: When reset-on-expiry is set, rst_req_o goes high the cycle after an expiry edge and stays high for exactly 128 clocks. With the bit clear, rst_req_o stays low.
- R7: With run enable clear, the count holds its value and neither output is raised.
- R8: A write to the prescale or divider fields while running takes effect only at the next prescaler terminal count. The prescaler period already in progress completes with the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Expiry interrupt flag (level) |
| rst_req_o | output | 1 | System reset request pulse |

## Verification
The bench sweeps every divider select against several prescale values and lands on the exact edge of the first and second decrement. A design with an off-by-one in either counter, or a wrong divider encoding, shows up one cycle early or late. Reload values 0 through 3 exercise expiry at the lower boundary. A design that counts down to zero before expiring gets the period wrong by one tick, and a design that mishandles a reload of zero does not expire on every tick. The reset pulse is sampled at its first and last high cycle, so a stretch of 127 or 129 clocks fails. A prescale change is written in the middle of a prescaler period; a design that applies the change at once places the first tick at the wrong edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int unsigned PRE_W     = 8;
  localparam int unsigned SEL_W     = 2;
  localparam int unsigned EN_BIT    = 0;
  localparam int unsigned RSTEN_BIT = 1;
  localparam int unsigned IRQEN_BIT = 2;
  localparam int unsigned SEL_LSB   = 3;
  localparam int unsigned FLAG_BIT  = 5;
  localparam int unsigned PRE_LSB   = 8;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_COUNT  = 2'd2,
    REG_NONE   = 2'd3
  } wd_reg_e;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [SEL_W-1:0] sel;
    logic             irq_en;
    logic             rst_en;
    logic             en;
  } wd_ctrl_t;

endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/wdog_scaler.sv
module wdog_scaler #(
  parameter int PRE_W     = 8,
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre_cfg,
  input  logic [SEL_W-1:0] sel_cfg,
  output logic             tick_o
);

  localparam int DIV_W = BASE_LOG2 + (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_cnt_q, pre_cnt_d;
  logic [PRE_W-1:0] pre_act_q, pre_act_d;
  logic [SEL_W-1:0] sel_act_q, sel_act_d;
  logic [DIV_W-1:0] div_cnt_q, div_cnt_d;
  logic [DIV_W-1:0] div_last;
  logic             pre_tc;
  logic             div_tc;

  // Last divider count for the active select: 2^(BASE+sel) - 1.
  always_comb begin
    div_last = DIV_W'((32'd1 << (BASE_LOG2 + 32'(sel_act_q))) - 32'd1);
  end

  assign pre_tc = run && (pre_cnt_q == pre_act_q);
  assign div_tc = (div_cnt_q >= div_last);
  assign tick_o = pre_tc && div_tc;

  always_comb begin
    pre_cnt_d = pre_cnt_q;
    pre_act_d = pre_act_q;
    sel_act_d = sel_act_q;
    div_cnt_d = div_cnt_q;
    if (!run) begin
      // Idle: restart from a clean period and track the programmed scale.
      pre_cnt_d = '0;
      div_cnt_d = '0;
      pre_act_d = pre_cfg;
      sel_act_d = sel_cfg;
    end else if (pre_tc) begin
      // Terminal count: the only point where new scale settings are taken.
      pre_cnt_d = '0;
      pre_act_d = pre_cfg;
      sel_act_d = sel_cfg;
      div_cnt_d = div_tc ? '0 : div_cnt_q + 1'b1;
    end else begin
      pre_cnt_d = pre_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt_q <= '0;
      pre_act_q <= '1;
      sel_act_q <= '1;
      div_cnt_q <= '0;
    end else begin
      pre_cnt_q <= pre_cnt_d;
      pre_act_q <= pre_act_d;
      sel_act_q <= sel_act_d;
      div_cnt_q <= div_cnt_d;
    end
  end

endmodule

// File: rtl/wdog_downcount.sv
module wdog_downcount #(
  parameter int               CNT_W   = 16,
  parameter logic [CNT_W-1:0] RST_VAL = 'h8000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  // A tick that would take the count to zero (or below) is the expiry.
  assign expire_o = tick && !load && (cnt_q <= CNT_W'(1));
  assign cnt_o    = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load)          cnt_d = load_val;
    else if (expire_o) cnt_d = reload_val;
    else if (tick)     cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_VAL;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int LEN = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse_o
);

  localparam int PW = $clog2(LEN + 1);

  logic [PW-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (trig)              left_d = PW'(LEN);
    else if (left_q != '0) left_d = left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign pulse_o = (left_q != '0);

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int               CNT_W     = 16,
  parameter int               BASE_LOG2 = 4,
  parameter int               RST_LEN   = 128,
  parameter logic [CNT_W-1:0] CNT_RESET = 'h8000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq_o,
  output logic             rst_req_o
);

  localparam wd_ctrl_t CTRL_RESET = '{pre: '1, sel: '1, irq_en: 1'b0,
                                      rst_en: 1'b1, en: 1'b1};

  logic             rst_sync_n;
  wd_ctrl_t         ctrl_q, ctrl_d;
  logic [CNT_W-1:0] data_q, data_d;
  logic             flag_q, flag_d;
  logic             wr_ctrl, wr_data, wr_cnt;
  logic             tick_w, expire_w;
  logic [CNT_W-1:0] count_w;
  logic             run_w, rst_en_w;

  wdog_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  assign wr_ctrl  = bus_we && (wd_reg_e'(bus_addr) == REG_CTRL);
  assign wr_data  = bus_we && (wd_reg_e'(bus_addr) == REG_RELOAD);
  assign wr_cnt   = bus_we && (wd_reg_e'(bus_addr) == REG_COUNT);
  assign run_w    = ctrl_q.en;
  assign rst_en_w = ctrl_q.rst_en;

  always_comb begin
    ctrl_d = ctrl_q;
    data_d = data_q;
    flag_d = flag_q;
    if (wr_ctrl) begin
      ctrl_d.pre    = bus_wdata[PRE_LSB +: PRE_W];
      ctrl_d.sel    = bus_wdata[SEL_LSB +: SEL_W];
      ctrl_d.irq_en = bus_wdata[IRQEN_BIT];
      ctrl_d.rst_en = bus_wdata[RSTEN_BIT];
      ctrl_d.en     = bus_wdata[EN_BIT];
      if (bus_wdata[FLAG_BIT]) flag_d = 1'b0;
    end
    if (wr_data) data_d = bus_wdata;
    // A fresh expiry wins over a clear in the same cycle.
    if (expire_w && ctrl_q.irq_en) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q <= CTRL_RESET;
      data_q <= CNT_RESET;
      flag_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      data_q <= data_d;
      flag_q <= flag_d;
    end
  end

  wdog_scaler #(
    .PRE_W     (PRE_W),
    .SEL_W     (SEL_W),
    .BASE_LOG2 (BASE_LOG2)
  ) u_scaler (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (run_w),
    .pre_cfg (ctrl_q.pre),
    .sel_cfg (ctrl_q.sel),
    .tick_o  (tick_w)
  );

  wdog_downcount #(
    .CNT_W   (CNT_W),
    .RST_VAL (CNT_RESET)
  ) u_count (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick       (tick_w),
    .load       (wr_cnt),
    .load_val   (bus_wdata),
    .reload_val (data_q),
    .cnt_o      (count_w),
    .expire_o   (expire_w)
  );

  wdog_pulse #(.LEN(RST_LEN)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .trig    (expire_w && rst_en_w),
    .pulse_o (rst_req_o)
  );

  always_comb begin
    case (wd_reg_e'(bus_addr))
      REG_CTRL:   bus_rdata = CNT_W'({ctrl_q.pre, 2'b00, flag_q, ctrl_q.sel,
                                      ctrl_q.irq_en, ctrl_q.rst_en, ctrl_q.en});
      REG_RELOAD: bus_rdata = data_q;
      REG_COUNT:  bus_rdata = count_w;
      default:    bus_rdata = '0;
    endcase
  end

  assign irq_o = flag_q;

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [1:0]       bus_addr,
  input logic [CNT_W-1:0] bus_wdata,
  input logic             irq_o,
  input logic             rst_req_o,
  input logic             expire,
  input logic             tick,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] data_q,
  input logic             run,
  input logic             rst_en
);

  logic cnt_wr, clr_wr;
  assign cnt_wr = bus_we && (wd_reg_e'(bus_addr) == REG_COUNT);
  assign clr_wr = bus_we && (wd_reg_e'(bus_addr) == REG_CTRL) && bus_wdata[FLAG_BIT];

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt_wr) |-> cnt_q == $past(bus_wdata));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick && !cnt_wr && !expire) |-> cnt_q == CNT_W'($past(cnt_q) - 1'b1));

  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(expire) |-> cnt_q == $past(data_q));

  p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !clr_wr) |=> irq_o);

  p_irq_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(expire));

  p_rst_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) |-> $past(expire && rst_en));

  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run && !cnt_wr) |-> $stable(cnt_q));

endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_o     (irq_o),
  .rst_req_o (rst_req_o),
  .expire    (expire_w),
  .tick      (tick_w),
  .cnt_q     (count_w),
  .data_q    (data_q),
  .run       (run_w),
  .rst_en    (rst_en_w)
);

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic        clk;
  logic        rst_n;
  logic        bus_we;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq_o;
  logic        rst_req_o;

  int n_checks = 0;
  int n_errs   = 0;

  wdog_timer dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; the write lands on the next rising edge.
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_we    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  function automatic logic [15:0] cw(input bit en, input bit rsten, input bit irqen,
                                     input int sel, input int pre, input bit clr);
    return {8'(pre), 2'b00, clr, 2'(sel), irqen, rsten, en};
  endfunction

  // Program with the timer stopped, then enable: the enable edge is E0.
  task automatic setup(input int pre, input int sel, input bit irqen, input bit rsten,
                       input logic [15:0] rel, input logic [15:0] cnt);
    wr(2'd0, cw(0, rsten, irqen, sel, pre, 1));
    wr(2'd1, rel);
    wr(2'd2, cnt);
    wr(2'd0, cw(1, rsten, irqen, sel, pre, 1));
  endtask

  initial begin
    #(CLK_PERIOD * WD_CYCLES);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    logic [15:0] v;
    bit seen;
    rst_n = 1'b0;
    bus_we = 1'b0;
    bus_addr = 2'd0;
    bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset values
    peek(2'd0, v); chk("R1 ctrl", 32'(v), 32'hFF1B);
    peek(2'd1, v); chk("R1 reload", 32'(v), 32'h8000);
    peek(2'd2, v); chk("R1 count", 32'(v), 32'h8000);
    peek(2'd3, v); chk("R1 unused addr", 32'(v), 32'h0);
    chk("R1 irq_o", 32'(irq_o), 0);
    chk("R1 rst_req_o", 32'(rst_req_o), 0);

    // R3: tick period sweep over prescale and every divider select
    for (int p = 0; p < 3; p++) begin
      for (int s = 0; s < 4; s++) begin
        int t;
        t = (p + 1) * (16 << s);
        setup(p, s, 0, 0, 16'd100, 16'd10);
        repeat (t - 1) @(negedge clk);
        peek(2'd2, v); chk("R3 before first tick", 32'(v), 10);
        @(negedge clk);
        peek(2'd2, v); chk("R3 first tick", 32'(v), 9);
        repeat (t) @(negedge clk);
        peek(2'd2, v); chk("R3 second tick", 32'(v), 8);
      end
    end

    // R4: expiry, reload and reload value zero
    for (int d = 0; d < 4; d++) begin
      for (int c = 0; c < 2; c++) begin
        int t, per;
        t = (c + 1) * (16 << c);
        per = ((d == 0) ? 1 : d) * t;
        setup(c, c, 1, 0, 16'(d), 16'(d));
        repeat (per - 1) @(negedge clk);
        chk("R4 no early expiry", 32'(irq_o), 0);
        @(negedge clk);
        chk("R4 expiry", 32'(irq_o), 1);
        peek(2'd2, v); chk("R4 reload value", 32'(v), 32'(d));
        wr(2'd0, cw(1, 0, 1, c, c, 1));
        chk("R5 flag cleared", 32'(irq_o), 0);
        repeat (per - 2) @(negedge clk);
        chk("R4 no early second expiry", 32'(irq_o), 0);
        @(negedge clk);
        chk("R4 periodic expiry", 32'(irq_o), 1);
      end
    end

    // R5: flag holds across a control write with bit 5 low, clears on 1
    setup(0, 0, 1, 0, 16'd5, 16'd1);
    repeat (16) @(negedge clk);
    chk("R5 set", 32'(irq_o), 1);
    wr(2'd0, cw(1, 0, 1, 0, 0, 0));
    chk("R5 kept on zero write", 32'(irq_o), 1);
    peek(2'd0, v); chk("R5 flag readback", 32'(v[5]), 1);
    repeat (20) @(negedge clk);
    chk("R5 level held", 32'(irq_o), 1);
    wr(2'd0, cw(1, 0, 1, 0, 0, 1));
    chk("R5 write-one clear", 32'(irq_o), 0);
    setup(0, 0, 0, 0, 16'd1, 16'd1);
    repeat (40) @(negedge clk);
    chk("R5 gated by enable bit", 32'(irq_o), 0);

    // R6: reset pulse length
    setup(0, 0, 0, 1, 16'd20, 16'd1);
    repeat (15) @(negedge clk);
    chk("R6 low before expiry", 32'(rst_req_o), 0);
    @(negedge clk);
    chk("R6 high after expiry", 32'(rst_req_o), 1);
    repeat (127) @(negedge clk);
    chk("R6 high at cycle 128", 32'(rst_req_o), 1);
    @(negedge clk);
    chk("R6 low after 128", 32'(rst_req_o), 0);
    chk("R6 no irq", 32'(irq_o), 0);
    setup(0, 0, 0, 0, 16'd1, 16'd1);
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (rst_req_o) seen = 1;
    end
    chk("R6 disabled stays low", 32'(seen), 0);

    // R7: stopped timer holds
    wr(2'd0, cw(0, 0, 1, 2, 3, 1));
    wr(2'd2, 16'd7);
    peek(2'd0, v); chk("R7 other fields kept", 32'(v), 32'(cw(0, 0, 1, 2, 3, 0)));
    repeat (300) @(negedge clk);
    peek(2'd2, v); chk("R7 count held", 32'(v), 7);
    chk("R7 no irq", 32'(irq_o), 0);
    chk("R7 no reset", 32'(rst_req_o), 0);

    // R2: direct load and keepalive
    wr(2'd2, 16'h1234);
    peek(2'd2, v); chk("R2 load", 32'(v), 32'h1234);
    setup(0, 0, 1, 1, 16'd3, 16'd3);
    seen = 0;
    for (int k = 0; k < 10; k++) begin
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (irq_o || rst_req_o) seen = 1;
      end
      wr(2'd2, 16'd3);
    end
    peek(2'd2, v); chk("R2 reload by write", 32'(v), 3);
    chk("R2 keepalive prevents expiry", 32'(seen), 0);

    // R8: prescale change deferred to terminal count
    wr(2'd0, cw(0, 0, 0, 0, 7, 1));
    wr(2'd2, 16'd50);
    wr(2'd1, 16'd50);
    wr(2'd0, cw(1, 0, 0, 0, 7, 1));
    repeat (2) @(negedge clk);
    wr(2'd0, cw(1, 0, 0, 0, 0, 0));
    repeat (19) @(negedge clk);
    peek(2'd2, v); chk("R8 no tick yet", 32'(v), 50);
    @(negedge clk);
    peek(2'd2, v); chk("R8 first tick at edge 23", 32'(v), 49);
    repeat (16) @(negedge clk);
    peek(2'd2, v); chk("R8 new period", 32'(v), 48);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

endmodule